// File: doc/BRIEF.md
# Latched Laser Safety Shutdown Controller

This block guards a laser transmitter. It watches two groups of alarm flags: one group from slow ADC limit comparisons and one from fast quick-trip comparators. When an alarm that software has enabled fires, the block latches a shutdown. The shutdown drives a gate pin that switches a series transistor off, and it removes the enable for the modulation and bias drivers. The shutdown stays latched after the alarm goes away. Only the transmit-disable pin, a soft disable bit or a reset releases it. The gate pin's asserted level is programmable, so the pin can drive either an n-channel or a p-channel switch. The pin stays undriven until the supply has been reported good.

Every alarm has a sticky trap bit, and the trap bit records the alarm whether or not the alarm is enabled for shutdown. Software clears trap bits by writing zeros to them. While the shutdown is latched the traps are frozen, so secondary alarms caused by the shutdown itself do not hide the root cause. A byte-wide register port holds the trap bytes, the shutdown enable masks and a control byte.

Top module: `laser_shutdown_ctrl`

## Requirements
- R1: After reset `en_o`=0, `gate_oe_o`=0 and `gate_o`=0. Every register reads 0: trap, mask and control.
- R2: `gate_oe_o` rises at the first clock edge that samples `supply_ok_i`=1. It then stays 1 until reset.
- R3: An alarm whose enable-mask bit is 0 never starts a shutdown. An alarm whose mask bit is 1 latches the shutdown at the edge that samples it. Mask bit 1 means enabled.
- R4: Once latched, the shutdown holds after its alarm clears. It is released only by the edge after `tx_dis_i`=1 or the edge after control bit 1 (soft disable) reads 1.
- R5: Control bit 0 is the polarity bit `dir`. While `gate_oe_o`=1, `gate_o` equals `dir` during shutdown and `~dir` otherwise.
- R6: `en_o` goes to 0 at the edge that samples `tx_dis_i`=1 or soft disable = 1. It also goes to 0 at the edge that samples an enabled alarm.
- R7: The enable follows the gate. On power-up `en_o` rises one cycle after `gate_oe_o`. On release the gate returns to idle while disable is held, and `en_o` rises at the first edge that samples disable low.
- R8: `en_o` goes to 0 at the edge that samples `supply_ok_i`=0. It returns to 1 one edge after the supply is good again, with no shutdown latched.
- R9: A trap bit is set at any edge that samples its alarm high, whatever its mask bit. It stays set after the alarm clears.
- R10: Writing a trap byte clears only the bits written as 0. Bits written as 1 have no effect. An alarm in the same cycle as a clear leaves its bit set.
- R11: While the shutdown is latched, no trap bit is set by new alarms.
- R12: The register map is fixed. Addresses 0–3 are trap bytes: byte k holds alarm 8k..8k+7, where alarms 0–15 are the ADC alarms and 16–31 the quick-trip alarms. Addresses 4–5 hold the ADC mask (low byte first) and 6–7 the quick-trip mask. Address 8 is control. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power cycle) |
| adc_alarm_i | input | N_ADC | ADC limit alarm flags |
| qt_alarm_i | input | N_QT | Quick-trip alarm flags |
| supply_ok_i | input | 1 | Supply above power-on-analog threshold |
| tx_dis_i | input | 1 | Transmit-disable pin |
| reg_addr_i | input | AW | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| gate_o | output | 1 | Shutdown gate level |
| gate_oe_o | output | 1 | Gate drive enable (0 = high impedance) |
| en_o | output | 1 | Modulation and bias output enable |

## Verification
The main function is tried with a table of alarm and mask pairs. The table holds an unmasked ADC alarm, an unmasked quick-trip alarm, alarms whose mask is only partly set and all masks set with no alarm. These separate a shutdown caused by a mask from one caused only by an alarm, and show that both groups are masked independently. Each entry also compares the trap contents with the raw alarm pattern. This shows that trapping ignores the mask. Directed cases release the shutdown through the pin and through the soft bit, with each polarity. Further directed cases drop the supply, and raise an alarm in the same cycle as a trap clear.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic soft_dis;
    logic dir;
  } ctrl_t;
endpackage

// File: rtl/lsc_regs.sv
module lsc_regs
  import lsc_pkg::*;
#(
  parameter int N_ADC = 16,
  parameter int N_QT  = 16,
  parameter int AW    = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [AW-1:0]         addr_i,
  input  logic                  we_i,
  input  logic [BYTE_W-1:0]     wdata_i,
  input  logic [N_ADC+N_QT-1:0] trap_i,
  output logic [BYTE_W-1:0]     rdata_o,
  output logic [N_ADC+N_QT-1:0] trap_keep_o,
  output logic [N_ADC-1:0]      adc_mask_o,
  output logic [N_QT-1:0]       qt_mask_o,
  output ctrl_t                 ctrl_o
);
  localparam int N_ALM = N_ADC + N_QT;
  localparam int NB_T  = N_ALM / BYTE_W;
  localparam int NB_A  = N_ADC / BYTE_W;
  localparam int NB_Q  = N_QT / BYTE_W;
  localparam int A_MA  = NB_T;
  localparam int A_MQ  = NB_T + NB_A;
  localparam int A_CTL = NB_T + NB_A + NB_Q;

  logic [N_ADC-1:0] adc_mask_q;
  logic [N_QT-1:0]  qt_mask_q;
  ctrl_t            ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adc_mask_q <= '0;
      qt_mask_q  <= '0;
      ctrl_q     <= '0;
    end else if (we_i) begin
      for (int b = 0; b < NB_A; b++)
        if (addr_i == AW'(A_MA + b)) adc_mask_q[BYTE_W*b +: BYTE_W] <= wdata_i;
      for (int b = 0; b < NB_Q; b++)
        if (addr_i == AW'(A_MQ + b)) qt_mask_q[BYTE_W*b +: BYTE_W] <= wdata_i;
      if (addr_i == AW'(A_CTL)) begin
        ctrl_q.dir      <= wdata_i[0];
        ctrl_q.soft_dis <= wdata_i[1];
      end
    end
  end

  // zero bits in a trap-byte write clear; everything else keeps
  for (genvar g = 0; g < NB_T; g++) begin : g_keep
    assign trap_keep_o[BYTE_W*g +: BYTE_W] =
      (we_i && addr_i == AW'(g)) ? wdata_i : {BYTE_W{1'b1}};
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NB_T; b++)
      if (addr_i == AW'(b)) rdata_o = trap_i[BYTE_W*b +: BYTE_W];
    for (int b = 0; b < NB_A; b++)
      if (addr_i == AW'(A_MA + b)) rdata_o = adc_mask_q[BYTE_W*b +: BYTE_W];
    for (int b = 0; b < NB_Q; b++)
      if (addr_i == AW'(A_MQ + b)) rdata_o = qt_mask_q[BYTE_W*b +: BYTE_W];
    if (addr_i == AW'(A_CTL)) rdata_o = {{(BYTE_W-2){1'b0}}, ctrl_q.soft_dis, ctrl_q.dir};
  end

  assign adc_mask_o = adc_mask_q;
  assign qt_mask_o  = qt_mask_q;
  assign ctrl_o     = ctrl_q;
endmodule

// File: rtl/lsc_trap.sv
module lsc_trap #(
  parameter int N_ALM = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ALM-1:0] alarm_i,
  input  logic             freeze_i,
  input  logic [N_ALM-1:0] keep_i,
  output logic [N_ALM-1:0] trap_o
);
  logic [N_ALM-1:0] trap_q;
  logic [N_ALM-1:0] set_w;

  assign set_w = freeze_i ? '0 : alarm_i;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trap_q <= '0;
    else         trap_q <= (trap_q & keep_i) | set_w;
  end

  assign trap_o = trap_q;
endmodule

// File: rtl/lsc_core.sv
module lsc_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  input  logic tx_dis_i,
  input  logic supply_ok_i,
  input  logic dir_i,
  output logic shut_o,
  output logic en_o,
  output logic gate_o,
  output logic gate_oe_o
);
  logic shut_q, pwr_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shut_q <= 1'b0;
      pwr_q  <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      pwr_q  <= pwr_q | supply_ok_i;
      shut_q <= tx_dis_i ? 1'b0 : (shut_q | trip_i);
      // pwr_q registered: enable trails gate drive by one cycle
      en_q   <= !tx_dis_i && !shut_q && !trip_i && pwr_q && supply_ok_i;
    end
  end

  assign shut_o    = shut_q;
  assign en_o      = en_q;
  assign gate_oe_o = pwr_q;
  assign gate_o    = pwr_q & (shut_q ? dir_i : ~dir_i);
endmodule

// File: rtl/laser_shutdown_ctrl.sv
module laser_shutdown_ctrl
  import lsc_pkg::*;
#(
  parameter int N_ADC = 16,
  parameter int N_QT  = 16,
  parameter int AW    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_ADC-1:0]  adc_alarm_i,
  input  logic [N_QT-1:0]   qt_alarm_i,
  input  logic              supply_ok_i,
  input  logic              tx_dis_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              gate_o,
  output logic              gate_oe_o,
  output logic              en_o
);
  localparam int N_ALM = N_ADC + N_QT;

  logic [N_ALM-1:0] alarm_w, trap_w, keep_w;
  logic [N_ADC-1:0] adc_mask_w;
  logic [N_QT-1:0]  qt_mask_w;
  ctrl_t            ctrl_w;
  logic             trip_w, dis_w, shut_w;

  assign alarm_w = {qt_alarm_i, adc_alarm_i};
  assign trip_w  = |(adc_alarm_i & adc_mask_w) | |(qt_alarm_i & qt_mask_w);
  assign dis_w   = tx_dis_i | ctrl_w.soft_dis;

  lsc_regs #(.N_ADC(N_ADC), .N_QT(N_QT), .AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .addr_i(reg_addr_i), .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .trap_i(trap_w), .rdata_o(reg_rdata_o), .trap_keep_o(keep_w),
    .adc_mask_o(adc_mask_w), .qt_mask_o(qt_mask_w), .ctrl_o(ctrl_w)
  );

  lsc_trap #(.N_ALM(N_ALM)) u_trap (
    .clk_i, .rst_ni,
    .alarm_i(alarm_w), .freeze_i(shut_w), .keep_i(keep_w), .trap_o(trap_w)
  );

  lsc_core u_core (
    .clk_i, .rst_ni,
    .trip_i(trip_w), .tx_dis_i(dis_w), .supply_ok_i,
    .dir_i(ctrl_w.dir), .shut_o(shut_w),
    .en_o, .gate_o, .gate_oe_o
  );
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
  parameter int N_ALM = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dis_i,
  input logic             supply_ok_i,
  input logic             reg_we_i,
  input logic             en_i,
  input logic             gate_i,
  input logic             gate_oe_i,
  input logic             shut_i,
  input logic             dir_i,
  input logic [N_ALM-1:0] trap_i
);
  p_oe_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_oe_i |=> gate_oe_i);

  p_latch_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shut_i && !dis_i) |=> shut_i);

  p_polarity_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_oe_i && shut_i) |-> (gate_i == dir_i));

  p_dis_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |=> !en_i);

  p_gate_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> (!shut_i && $past(gate_oe_i)));

  p_supply_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> !en_i);

  p_trap_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shut_i && !reg_we_i) |=> $stable(trap_i));
endmodule

bind laser_shutdown_ctrl lsc_checker #(.N_ALM(N_ALM)) u_lsc_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .dis_i(dis_w), .supply_ok_i(supply_ok_i),
  .reg_we_i(reg_we_i), .en_i(en_o), .gate_i(gate_o), .gate_oe_i(gate_oe_o),
  .shut_i(shut_w), .dir_i(ctrl_w.dir), .trap_i(trap_w)
);

// File: tb/test_laser_shutdown_ctrl.sv
module test_laser_shutdown_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] adc = '0, qt = '0;
  logic        sup = 1'b0, txd = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0, rdata;
  logic        gate, gate_oe, en;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  laser_shutdown_ctrl i_laser_shutdown_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .adc_alarm_i(adc), .qt_alarm_i(qt),
    .supply_ok_i(sup), .tx_dis_i(txd), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .gate_o(gate),
    .gate_oe_o(gate_oe), .en_o(en)
  );

  // {adc, qt, adc_mask, qt_mask, expect_shutdown}
  localparam logic [64:0] TBL [6] = '{
    {16'h0001, 16'h0000, 16'h0000, 16'h0000, 1'b0},
    {16'h0001, 16'h0000, 16'h0001, 16'h0000, 1'b1},
    {16'h0000, 16'h8000, 16'h0000, 16'h8000, 1'b1},
    {16'h00F0, 16'h0000, 16'h0F00, 16'h0000, 1'b0},
    {16'h0200, 16'h0100, 16'h0200, 16'h0000, 1'b1},
    {16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 1'b0}
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    step();
    we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [7:0] exp);
    addr = a; #1;
    chk(req, 32'(rdata), 32'(exp));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] tr;
    #12 rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 en", 32'(en), 0);
    chk("R1 oe", 32'(gate_oe), 0);
    chk("R1 gate", 32'(gate), 0);
    for (int a = 0; a < 9; a++) rd_chk("R1 regs", 4'(a), 8'h00);
    rd_chk("R12 unused", 4'd9, 8'h00);

    // R2 / R7 power-up sequence
    sup = 1'b1;
    step();
    chk("R2 oe up", 32'(gate_oe), 1);
    chk("R7 en trails", 32'(en), 0);
    step();
    chk("R7 en up", 32'(en), 1);
    chk("R5 idle dir0", 32'(gate), 1);

    // table walk: R3 R6 R9 R4
    foreach (TBL[i]) begin
      logic [15:0] va, vq, ma, mq;
      logic        ex;
      {va, vq, ma, mq, ex} = TBL[i];
      wr(4, ma[7:0]); wr(5, ma[15:8]); wr(6, mq[7:0]); wr(7, mq[15:8]);
      for (int k = 0; k < 4; k++) wr(4'(k), 8'h00);
      txd = 1'b1; step(); txd = 1'b0; step(); step();
      adc = va; qt = vq;
      step();
      adc = '0; qt = '0;
      chk("R3 gate", 32'(gate), ex ? 0 : 1);
      chk("R6 en", 32'(en), ex ? 0 : 1);
      tr = {vq, va};
      for (int k = 0; k < 4; k++) rd_chk("R9 trap", 4'(k), tr[8*k +: 8]);
      step(); step(); step();
      chk("R4 latched", 32'(gate), ex ? 0 : 1);
    end
    txd = 1'b1; step(); txd = 1'b0; step(); step();

    // R5 polarity with dir=1, R7 release by pin
    wr(8, 8'h01);
    chk("R5 idle dir1", 32'(gate), 0);
    wr(4, 8'h01); wr(5, 8'h00); wr(6, 8'h00); wr(7, 8'h00);
    adc = 16'h0001; step(); adc = '0;
    chk("R5 shut dir1", 32'(gate), 1);
    txd = 1'b1; step();
    chk("R7 gate released", 32'(gate), 0);
    chk("R7 en held", 32'(en), 0);
    txd = 1'b0; step();
    chk("R7 en after", 32'(en), 1);

    // R11 frozen trap, R4 release by soft bit
    for (int k = 0; k < 4; k++) wr(4'(k), 8'h00);
    adc = 16'h0001; step(); adc = '0;
    qt = 16'h0008; step(); qt = '0;
    rd_chk("R11 qt frozen", 4'd2, 8'h00);
    rd_chk("R11 root kept", 4'd0, 8'h01);
    wr(8, 8'h03);
    step();
    chk("R4 soft release", 32'(gate), 0);
    chk("R6 soft en", 32'(en), 0);
    wr(8, 8'h01); step(); step();
    chk("R4 soft en back", 32'(en), 1);

    // R10 write-zero clear, set wins
    wr(4, 8'h00);
    adc = 16'h0001; step(); adc = '0;
    rd_chk("R9 sticky", 4'd0, 8'h01);
    wr(0, 8'hFF);
    rd_chk("R10 ones ignored", 4'd0, 8'h01);
    wr(0, 8'hFE);
    rd_chk("R10 zero clears", 4'd0, 8'h00);
    adc = 16'h0002; wr(0, 8'h00); adc = '0;
    rd_chk("R10 set wins", 4'd0, 8'h02);

    // R8 supply loss
    sup = 1'b0; step();
    chk("R8 en off", 32'(en), 0);
    chk("R2 oe kept", 32'(gate_oe), 1);
    sup = 1'b1; step();
    chk("R8 en back", 32'(en), 1);

    // R12 map
    wr(6, 8'hA5);
    rd_chk("R12 qt mask", 4'd6, 8'hA5);
    rd_chk("R12 ctrl", 4'd8, 8'h01);
    rd_chk("R12 unused hi", 4'd15, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule